// File: doc/BRIEF.md
# Processor On-Chip I/O Port

This block is the small parallel port built into a processor's address space. Address 0 holds a per-bit direction register (1 = output) and address 1 holds the port data register. The port returns the value a program would read back from both locations. It also produces three memory-configuration lines for the external address decoder. Every other address reads the RAM data that is handed in.

The two top bits of the port have no pins. When one of them is an input, it returns a stored "floating charge" value. That value is captured when the bit is switched from output to input, or when the data register is written while the bit is an output. It drops to zero once a fixed number of cycles has passed, counted on an externally supplied free-running cycle counter.

Every bus write is passed on to the RAM below at the same address. For the two port addresses, the byte passed on is the last byte seen on the bus, not the value that was written.

Top module: `cpu_io_port`

## Requirements
- R1: After reset the direction register reads 0x00, address 1 reads 0x1F, and `mem_cfg` is 3'b111.
- R2: A write to address 0 loads the direction register; a read of address 0 returns it on the next cycle.
- R3: Bits 0..5 of an address-1 read equal (data | ~dir) & (pins | 0x17), with bit 5 forced to 0 while direction bit 5 is 0. Pin bits follow data where the direction bit is 1 and keep their previous value where it is 0.
- R4: `mem_cfg` equals bits 2..0 of (data | ~dir), so input bits drive 1.
- R5: While direction bit 6 or 7 is 1, that bit of an address-1 read equals the data register bit.
- R6: Writing address 0 so that direction bit 6 or 7 goes from 1 to 0 captures the current data bit as that bit's charge, which an address-1 read then returns.
- R7: Writing address 1 while direction bit 6 or 7 is 0 leaves that bit's charge unchanged.
- R8: A charge still reads as captured when `cycle_now` equals the capture cycle plus DECAY_CYCLES (default 350000), and reads 0 once `cycle_now` is greater than that.
- R9: Each bus write asserts `ram_wr` at `bus_addr`. Data is `bus_last` for addresses 0 and 1 and `bus_wdata` otherwise.
- R10: Reads of any address above 1 return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_last | input | 8 | Last byte seen on the bus |
| cycle_now | input | CYC_W | Free-running cycle count |
| ram_rdata | input | 8 | Read data from RAM |
| rd_data | output | 8 | Read data for `bus_addr` |
| mem_cfg | output | 3 | Memory-configuration lines to the decoder |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |

## Verification
A register write and the expiry of a floating charge can happen at the same clock edge. In that case the fresh capture must win over the clear. The constrained-random phase provokes this by advancing `cycle_now` in large random jumps while direction and data writes land on random addresses. Every read is then judged against a bench model that applies the same capture-before-expiry order.

// File: rtl/cpu_io_pkg.sv
package cpu_io_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CFG_W       = 3;
  localparam int unsigned FLOAT_BASE  = 6;
  localparam int unsigned FLOAT_N     = 2;
  localparam int unsigned FORCED_BIT  = 5;
  localparam logic [7:0]  RESET_DATA  = 8'h3F;
  localparam logic [7:0]  RESET_DIR   = 8'h00;
  localparam logic [7:0]  PULL_MASK   = 8'h17;
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
  import cpu_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] dir_q,
  output logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] pins_q
);
  logic [BYTE_W-1:0] dir_n, data_n, pins_n;
  logic              reg_en;

  always_comb begin
    dir_n  = dir_q;
    data_n = data_q;
    if (wr_dir)  dir_n  = wdata;
    if (wr_data) data_n = wdata;
    pins_n = (pins_q & ~dir_n) | (data_n & dir_n);
    reg_en = wr_dir | wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= RESET_DIR;
      data_q <= RESET_DATA;
      pins_q <= RESET_DATA;
    end else if (reg_en) begin
      dir_q  <= dir_n;
      data_q <= data_n;
      pins_q <= pins_n;
    end
  end
endmodule

// File: rtl/io_charge_cell.sv
module io_charge_cell #(
  parameter int unsigned CYC_W        = 32,
  parameter int unsigned DECAY_CYCLES = 350000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_val,
  input  logic [CYC_W-1:0] cycle_now,
  output logic             charge_o
);
  localparam logic [CYC_W-1:0] DECAY = CYC_W'(DECAY_CYCLES);

  logic             charge_q, charge_n;
  logic             fall_q, fall_n;
  logic [CYC_W-1:0] limit_q, limit_n;
  logic             expired, cell_en;

  always_comb begin
    expired  = fall_q && (cycle_now > limit_q);
    charge_o = charge_q & ~expired;
    charge_n = charge_q;
    fall_n   = fall_q;
    limit_n  = limit_q;
    if (load) begin
      charge_n = load_val;
      fall_n   = 1'b1;
      limit_n  = cycle_now + DECAY;
    end else if (expired) begin
      charge_n = 1'b0;
      fall_n   = 1'b0;
    end
    cell_en = load | expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      charge_q <= 1'b0;
      fall_q   <= 1'b0;
      limit_q  <= '0;
    end else if (cell_en) begin
      charge_q <= charge_n;
      fall_q   <= fall_n;
      limit_q  <= limit_n;
    end
  end
endmodule

// File: rtl/io_port_view.sv
module io_port_view
  import cpu_io_pkg::*;
(
  input  logic [BYTE_W-1:0]  dir_q,
  input  logic [BYTE_W-1:0]  data_q,
  input  logic [BYTE_W-1:0]  pins_q,
  input  logic [FLOAT_N-1:0] charge_bits,
  output logic [BYTE_W-1:0]  port_val,
  output logic [CFG_W-1:0]   cfg
);
  logic [BYTE_W-1:0] driven;

  always_comb begin
    driven   = data_q | ~dir_q;
    port_val = driven & (pins_q | PULL_MASK);
    if (!dir_q[FORCED_BIT]) port_val[FORCED_BIT] = 1'b0;
    for (int i = 0; i < FLOAT_N; i++) begin
      if (!dir_q[FLOAT_BASE+i]) port_val[FLOAT_BASE+i] = charge_bits[i];
    end
    cfg = driven[CFG_W-1:0];
  end
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
  import cpu_io_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned CYC_W        = 32,
  parameter int unsigned DECAY_CYCLES = 350000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_last,
  input  logic [CYC_W-1:0]  cycle_now,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        rd_data,
  output logic [2:0]        mem_cfg,
  output logic              ram_wr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1);

  logic               hit_dir, hit_data, wr_dir, wr_data;
  logic [BYTE_W-1:0]  dir_q, data_q, pins_q, port_val;
  logic [FLOAT_N-1:0] charge_bits;

  assign hit_dir  = (bus_addr == DIR_ADDR);
  assign hit_data = (bus_addr == DATA_ADDR);
  assign wr_dir   = bus_wr & hit_dir;
  assign wr_data  = bus_wr & hit_data;

  io_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_data(wr_data),
    .wdata(bus_wdata), .dir_q(dir_q), .data_q(data_q), .pins_q(pins_q)
  );

  generate
    for (genvar g = 0; g < FLOAT_N; g++) begin : g_float
      localparam int unsigned B = FLOAT_BASE + g;
      logic ld, ld_val;
      assign ld = (wr_data && dir_q[B]) || (wr_dir && dir_q[B] && !bus_wdata[B]);
      assign ld_val = wr_data ? bus_wdata[B] : data_q[B];
      io_charge_cell #(.CYC_W(CYC_W), .DECAY_CYCLES(DECAY_CYCLES)) u_cell (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .cycle_now(cycle_now), .charge_o(charge_bits[g])
      );
    end
  endgenerate

  io_port_view u_view (
    .dir_q(dir_q), .data_q(data_q), .pins_q(pins_q),
    .charge_bits(charge_bits), .port_val(port_val), .cfg(mem_cfg)
  );

  always_comb begin
    if (hit_dir)       rd_data = dir_q;
    else if (hit_data) rd_data = port_val;
    else               rd_data = ram_rdata;
    ram_wr    = bus_wr;
    ram_addr  = bus_addr;
    ram_wdata = (hit_dir | hit_data) ? bus_last : bus_wdata;
  end
endmodule

// File: rtl/cpu_io_port_chk.sv
module cpu_io_port_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_last,
  input logic [7:0]        ram_rdata,
  input logic [7:0]        rd_data,
  input logic [2:0]        mem_cfg,
  input logic              ram_wr,
  input logic [7:0]        ram_wdata,
  input logic [7:0]        dir_q,
  input logic [1:0]        charge_bits
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> dir_q == $past(bus_wdata));

  assert_bit5_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(1) && !dir_q[5]) |-> !rd_data[5]);

  assert_cfg_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q[2:0] == 3'b000) |-> mem_cfg == 3'b111);

  assert_charge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && !dir_q[6])
      |=> (charge_bits[0] == $past(charge_bits[0])) || !charge_bits[0]);

  assert_ram_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr < ADDR_W'(2)) |-> (ram_wr && ram_wdata == bus_last));

  assert_ram_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(1)) |-> rd_data == ram_rdata);
endmodule

bind cpu_io_port cpu_io_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_last(bus_last), .ram_rdata(ram_rdata),
  .rd_data(rd_data), .mem_cfg(mem_cfg), .ram_wr(ram_wr),
  .ram_wdata(ram_wdata), .dir_q(dir_q), .charge_bits(charge_bits)
);

// File: tb/tb_cpu_io_port.sv
module tb_cpu_io_port;
  localparam int CLK_PERIOD = 10;
  localparam int DECAY      = 350000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata, bus_last, ram_rdata;
  logic [31:0] cycle_now;
  logic [7:0]  rd_data, ram_wdata;
  logic [2:0]  mem_cfg;
  logic        ram_wr;
  logic [15:0] ram_addr;

  int vectors = 0;
  int errors  = 0;

  logic [7:0]  m_dir, m_data, m_pins;
  logic [1:0]  m_ch, m_fall;
  logic [31:0] m_lim [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_io_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_last(bus_last), .cycle_now(cycle_now),
    .ram_rdata(ram_rdata), .rd_data(rd_data), .mem_cfg(mem_cfg),
    .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_port();
    logic [7:0] v;
    v = (m_data | ~m_dir) & (m_pins | 8'h17);
    if (!m_dir[5]) v[5] = 1'b0;
    for (int i = 0; i < 2; i++)
      if (!m_dir[6+i]) v[6+i] = m_ch[i] && !(m_fall[i] && cycle_now > m_lim[i]);
    return v;
  endfunction

  function automatic logic [7:0] exp_read();
    if (bus_addr == 16'd0) return m_dir;
    if (bus_addr == 16'd1) return exp_port();
    return ram_rdata;
  endfunction

  task automatic model_reset();
    m_dir = 8'h00; m_data = 8'h3F; m_pins = 8'h3F; m_ch = 2'b00; m_fall = 2'b00;
    m_lim[0] = '0; m_lim[1] = '0;
  endtask

  task automatic model_edge();
    logic [7:0] nd, nt;
    nd = m_dir; nt = m_data;
    for (int i = 0; i < 2; i++) begin
      logic ld, lv;
      ld = bus_wr && m_dir[6+i] &&
           (bus_addr == 16'd1 || (bus_addr == 16'd0 && !bus_wdata[6+i]));
      lv = (bus_addr == 16'd1) ? bus_wdata[6+i] : m_data[6+i];
      if (ld) begin
        m_ch[i] = lv; m_fall[i] = 1'b1; m_lim[i] = cycle_now + DECAY;
      end else if (m_fall[i] && cycle_now > m_lim[i]) begin
        m_ch[i] = 1'b0; m_fall[i] = 1'b0;
      end
    end
    if (bus_wr && bus_addr == 16'd0) nd = bus_wdata;
    if (bus_wr && bus_addr == 16'd1) nt = bus_wdata;
    m_dir = nd; m_data = nt;
    m_pins = (m_pins & ~m_dir) | (m_data & m_dir);
  endtask

  // One bus cycle: drive, check combinational outputs, commit at the edge.
  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] wd);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = wd;
    bus_last = 8'($urandom); ram_rdata = 8'($urandom);
    #1;
    if (a == 16'd0)      check("R2 dir read", {8'h0, rd_data}, {8'h0, exp_read()});
    else if (a == 16'd1) check("R3 port read", {8'h0, rd_data}, {8'h0, exp_read()});
    else                 check("R10 ram read", {8'h0, rd_data}, {8'h0, ram_rdata});
    check("R4 mem_cfg", {13'h0, mem_cfg}, {13'h0, m_data[2:0] | ~m_dir[2:0]});
    if (w) begin
      check("R9 ram_wr/addr", {ram_wr, ram_addr[14:0]}, {1'b1, a[14:0]});
      check("R9 ram_wdata", {8'h0, ram_wdata}, {8'h0, (a < 16'd2) ? bus_last : wd});
    end
    @(posedge clk);
    model_edge();
    #1;
    bus_wr = 1'b0;
    cycle_now = cycle_now + 32'd1;
  endtask

  task automatic expect_port(input string tag, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = 16'd1; bus_wr = 1'b0;
    #1;
    check(tag, {8'h0, rd_data}, {8'h0, exp});
    check({tag, " model"}, {8'h0, exp_port()}, {8'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] cap;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_last = '0; ram_rdata = '0; cycle_now = 32'd100;
    model_reset();
    do_reset();

    // R1: reset state
    @(negedge clk); bus_addr = 16'd0; #1;
    check("R1 dir reset", {8'h0, rd_data}, 16'h0000);
    expect_port("R1 port reset", 8'h1F);
    check("R1 mem_cfg reset", {13'h0, mem_cfg}, 16'h0007);

    // R3: input pin keeps value last driven
    step(16'd0, 1'b1, 8'h08);
    step(16'd1, 1'b1, 8'h37);
    step(16'd0, 1'b1, 8'h00);
    expect_port("R3 held pin", 8'h17);
    // R4: configuration lines follow outputs
    step(16'd0, 1'b1, 8'h07);
    step(16'd1, 1'b1, 8'h32);
    @(negedge clk); #1;
    check("R4 cfg driven", {13'h0, mem_cfg}, 16'h0002);

    // R5..R8: floating top bits
    do_reset();
    step(16'd0, 1'b1, 8'hC0);
    step(16'd1, 1'b1, 8'hC0);
    expect_port("R5 output bits high", 8'hDF);
    step(16'd1, 1'b1, 8'h40);
    expect_port("R5 output bit7 low", 8'h5F);
    step(16'd1, 1'b1, 8'hC0);
    cap = cycle_now;
    step(16'd0, 1'b1, 8'h00);
    expect_port("R6 captured charge", 8'hDF);
    step(16'd1, 1'b1, 8'h00);
    expect_port("R7 charge untouched", 8'hDF);
    @(negedge clk); cycle_now = cap + DECAY;
    expect_port("R8 boundary still valid", 8'hDF);
    step(16'd2, 1'b0, 8'h00);
    expect_port("R8 decayed", 8'h1F);
    step(16'd0, 1'b1, 8'h00);
    expect_port("R8 stays decayed", 8'h1F);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      a = 16'($urandom % 4);
      if ($urandom % 16 == 0) a = 16'($urandom);
      if ($urandom % 40 == 0) cycle_now = cycle_now + ($urandom % 400000);
      step(a, ($urandom % 2) == 1, 8'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule